// File: doc/BRIEF.md
# Masked Interrupt Status Register Group

This block is the interrupt-reporting corner of a clock and reset controller. It keeps a small set of sticky status bits that hardware event inputs set. It also keeps a mask with one bit for each status bit, and it drives one level-sensitive interrupt line. The line is active while any status bit is set and its mask bit is clear.

Software reaches the block over a plain 32-bit register bus. The bus has an address, a write strobe, write data and combinational read data. Software clears status bits by writing ones to them. The mask cannot be written directly. It moves only through two strobe addresses that hold no state: writing to one of them unmasks every bit given as 1 in the data, and writing to the other masks every such bit. Every access is a whole aligned 32-bit word, and bit i of the data belongs to source i. The number of sources is a parameter. It defaults to one source, which gives the usual single-bit arrangement.

Word map, as byte offsets: status at 0x0, mask at 0x4, unmask strobe at 0x8, mask strobe at 0xC.

Top module: `irq_reg_group`

## Requirements
- R1: After a synchronous active-low reset, status reads 0, mask reads all ones in its NUM_SRC low bits (0x1 with one source), and irq_o is 0.
- R2: irq_o is a register. One clock after any change, it equals the OR over all bits of (status AND NOT mask), taken from the values status and mask had in the cycle before.
- R3: When hw_evt[i] is high at a clock edge, status bit i is 1 after that edge.
- R4: A write to the status word (offset 0x0) clears each status bit whose data bit is 1. Data bits that are 0 leave their status bits unchanged.
- R5: If hw_evt[i] is high in the same cycle as a status write that clears bit i, bit i ends up set.
- R6: A write to the unmask strobe (offset 0x8) clears every mask bit whose data bit is 1 and leaves the other mask bits alone.
- R7: A write to the mask strobe (offset 0xC) sets every mask bit whose data bit is 1 and leaves the other mask bits alone. Data bits at or above NUM_SRC are ignored.
- R8: A write to the mask word (offset 0x4) has no effect. The mask changes only through the two strobe addresses.
- R9: The unmask and mask strobe addresses read back as 0 at all times, including right after they have been written.
- R10: A write whose address has bits [1:0] not equal to 0 changes nothing. A read from such an address, or from any unmapped word, returns 0.
- R11: The status and mask words return their bits in positions [NUM_SRC-1:0], with 0 in every higher position.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wr_en | input | 1 | Write strobe, one cycle for each write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| hw_evt | input | NUM_SRC | Event inputs, one for each status bit; a high level at an edge sets the bit |
| irq_o | output | 1 | Registered interrupt line, active high |

## Verification
The bench builds the block with NUM_SRC = 4 and ADDR_W = 8. With four sources, some bits can be masked while others are not. A single write can clear one bit while an event sets another. Unmask and mask strobes can then be shown to touch only the bits named in their data. The 8-bit address also reaches misaligned and unmapped words, and the one-clock lag of the interrupt line is checked edge by edge against a bench model of status and mask.

// File: rtl/irq_grp_pkg.sv
// Package: shared constants and the decoded-strobe type for the interrupt
// register group. Word indices are byte offsets divided by four.
package irq_grp_pkg;

    localparam int unsigned DATA_W     = 32;

    // Word indices of the four mapped locations
    localparam int unsigned IDX_STATUS  = 0;
    localparam int unsigned IDX_MASK    = 1;
    localparam int unsigned IDX_UNMASK  = 2;
    localparam int unsigned IDX_DOMASK  = 3;

    // Decoded bus strobes; only aligned addresses ever raise a field
    typedef struct packed {
        logic sts_wr;    // write-one-to-clear on status
        logic unm_wr;    // unmask strobe write
        logic dom_wr;    // mask strobe write
        logic sts_rd;    // status word selected for read
        logic msk_rd;    // mask word selected for read
    } irq_dec_t;

endpackage

// File: rtl/irq_addr_decode.sv
// Module: irq_addr_decode
// Turns the byte address and write strobe into one-hot strobes for the
// register group. Assumes whole-word accesses: any address with low bits
// set decodes to nothing, so it neither writes nor reads.
module irq_addr_decode
    import irq_grp_pkg::*;
#(
    parameter int unsigned ADDR_W = 12
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    output irq_dec_t          dec
);

    localparam int unsigned IDX_W = ADDR_W - 2;

    logic             aligned;
    logic [IDX_W-1:0] word_idx;
    logic             hit_sts, hit_msk, hit_unm, hit_dom;

    assign aligned  = (addr[1:0] == 2'b00);
    assign word_idx = addr[ADDR_W-1:2];

    // Compare the word index against each mapped location
    always_comb begin
        hit_sts = aligned && (word_idx == IDX_W'(IDX_STATUS));
        hit_msk = aligned && (word_idx == IDX_W'(IDX_MASK));
        hit_unm = aligned && (word_idx == IDX_W'(IDX_UNMASK));
        hit_dom = aligned && (word_idx == IDX_W'(IDX_DOMASK));
    end

    // Qualify the hits with the write strobe; reads need only the hit
    always_comb begin
        dec.sts_wr = hit_sts && wr_en;
        dec.unm_wr = hit_unm && wr_en;
        dec.dom_wr = hit_dom && wr_en;
        dec.sts_rd = hit_sts;
        dec.msk_rd = hit_msk;
    end

endmodule

// File: rtl/irq_status_bank.sv
// Module: irq_status_bank
// Sticky status bits, one for each event source. An event sets its bit. A
// status write with a 1 in the bit's data position clears it. When both
// happen in one cycle, the set wins, so no event is lost.
module irq_status_bank #(
    parameter int unsigned NUM_SRC = 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] evt,
    input  logic               clr_wr,
    input  logic [NUM_SRC-1:0] clr_data,
    output logic [NUM_SRC-1:0] sts_q
);

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
        // One sticky bit: event beats clear
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sts_q[i] <= 1'b0;
            end else if (evt[i]) begin
                sts_q[i] <= 1'b1;
            end else if (clr_wr && clr_data[i]) begin
                sts_q[i] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/irq_mask_bank.sv
// Module: irq_mask_bank
// Mask bits with no direct bus write. The unmask strobe clears the named
// bits and the mask strobe sets them. The two strobes come from different
// addresses, so they never arrive together. Reset masks every source.
module irq_mask_bank #(
    parameter int unsigned NUM_SRC = 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               unm_wr,
    input  logic               dom_wr,
    input  logic [NUM_SRC-1:0] sel_data,
    output logic [NUM_SRC-1:0] msk_q
);

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
        // One mask bit, moved only by the strobes
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                msk_q[i] <= 1'b1;
            end else if (dom_wr && sel_data[i]) begin
                msk_q[i] <= 1'b1;
            end else if (unm_wr && sel_data[i]) begin
                msk_q[i] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/irq_line_reg.sv
// Module: irq_line_reg
// Reduces status AND NOT mask to one bit and registers it. The line
// therefore follows any status or mask change one clock later, and it
// leaves the block without glitches.
module irq_line_reg #(
    parameter int unsigned NUM_SRC = 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] sts,
    input  logic [NUM_SRC-1:0] msk,
    output logic               irq_q
);

    logic pend;

    // Any unmasked pending source
    assign pend = |(sts & ~msk);

    // Register the line
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= pend;
        end
    end

endmodule

// File: rtl/irq_reg_group.sv
// Module: irq_reg_group (top)
// Interrupt status and mask register group on a simple 32-bit register
// bus. Assumes single-cycle writes, whole aligned words and little-endian
// bit numbering (data bit i belongs to source i). Reads are combinational
// from the address. NUM_SRC must be between 1 and 32.
module irq_reg_group
    import irq_grp_pkg::*;
#(
    parameter int unsigned NUM_SRC = 1,
    parameter int unsigned ADDR_W  = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_wr_en,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    input  logic [NUM_SRC-1:0]  hw_evt,
    output logic                irq_o
);

    irq_dec_t           dec;
    logic [NUM_SRC-1:0] sts_q;
    logic [NUM_SRC-1:0] msk_q;
    logic [NUM_SRC-1:0] wsel;
    logic               unused_wdata_hi;

    // Only the low NUM_SRC data bits carry meaning
    assign wsel            = bus_wdata[NUM_SRC-1:0];
    assign unused_wdata_hi = ^bus_wdata;

    irq_addr_decode #(.ADDR_W(ADDR_W)) dec_i (
        .addr  (bus_addr),
        .wr_en (bus_wr_en),
        .dec   (dec)
    );

    irq_status_bank #(.NUM_SRC(NUM_SRC)) sts_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt      (hw_evt),
        .clr_wr   (dec.sts_wr),
        .clr_data (wsel),
        .sts_q    (sts_q)
    );

    irq_mask_bank #(.NUM_SRC(NUM_SRC)) msk_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .unm_wr   (dec.unm_wr),
        .dom_wr   (dec.dom_wr),
        .sel_data (wsel),
        .msk_q    (msk_q)
    );

    irq_line_reg #(.NUM_SRC(NUM_SRC)) line_i (
        .clk   (clk),
        .rst_n (rst_n),
        .sts   (sts_q),
        .msk   (msk_q),
        .irq_q (irq_o)
    );

    // Read mux: strobe addresses and everything unmapped return zero
    always_comb begin
        bus_rdata = '0;
        if (dec.sts_rd) begin
            bus_rdata = DATA_W'(sts_q);
        end else if (dec.msk_rd) begin
            bus_rdata = DATA_W'(msk_q);
        end
    end

endmodule

// File: rtl/irq_reg_group_chk.sv
// Module: irq_reg_group_chk
// Assertion checker bound to irq_reg_group. It watches the bus, the event
// inputs, the status and mask state, and the interrupt line.
module irq_reg_group_chk
    import irq_grp_pkg::*;
#(
    parameter int unsigned NUM_SRC = 1,
    parameter int unsigned ADDR_W  = 12
) (
    input logic               clk,
    input logic               rst_n,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic               bus_wr_en,
    input logic [DATA_W-1:0]  bus_wdata,
    input logic [DATA_W-1:0]  bus_rdata,
    input logic [NUM_SRC-1:0] hw_evt,
    input logic [NUM_SRC-1:0] sts,
    input logic [NUM_SRC-1:0] msk,
    input logic               irq_o
);

    localparam logic [ADDR_W-1:0] A_UNM = ADDR_W'(IDX_UNMASK * 4);
    localparam logic [ADDR_W-1:0] A_DOM = ADDR_W'(IDX_DOMASK * 4);

    logic               wr_unm, wr_dom;
    logic [NUM_SRC-1:0] wlo;

    assign wr_unm = bus_wr_en && (bus_addr == A_UNM);
    assign wr_dom = bus_wr_en && (bus_addr == A_DOM);
    assign wlo    = bus_wdata[NUM_SRC-1:0];

    // R2: line is last cycle's unmasked pending
    assert_irq_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_o == |($past(sts) & ~$past(msk))));

    // R3, R5: an event leaves its bit set whatever else happens
    assert_evt_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (|hw_evt) |=> ((sts & $past(hw_evt)) == $past(hw_evt)));

    // R6: unmask strobe clears the named mask bits
    assert_unmask_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_unm |=> ((msk & $past(wlo)) == '0));

    // R7: mask strobe sets the named mask bits
    assert_mask_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_dom |=> ((msk & $past(wlo)) == $past(wlo)));

    // R8: without a strobe write the mask holds
    assert_mask_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_unm || wr_dom) |=> $stable(msk));

    // R9: strobe addresses read as zero
    assert_strobe_reads_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_addr == A_UNM) || (bus_addr == A_DOM)) |-> (bus_rdata == '0));

endmodule

bind irq_reg_group irq_reg_group_chk #(
    .NUM_SRC (NUM_SRC),
    .ADDR_W  (ADDR_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr_en (bus_wr_en),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .hw_evt    (hw_evt),
    .sts       (sts_q),
    .msk       (msk_q),
    .irq_o     (irq_o)
);

// File: tb/irq_reg_group_tb_top.sv
// Scoreboard bench: driver tasks keep a model of status and mask and push
// expected read results into a queue. A monitor pops each item and
// compares it with the read data and the interrupt line.
module irq_reg_group_tb_top;

    localparam int unsigned NS = 4;
    localparam int unsigned AW = 8;

    typedef struct {
        logic [31:0] rd;
        logic        irq;
        string       tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic          bus_wr_en = 1'b0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NS-1:0] hw_evt = '0;
    logic          irq_o;

    logic [NS-1:0] m_sts = '0;
    logic [NS-1:0] m_msk = '1;
    logic          rd_pend = 1'b0;
    logic          done = 1'b0;
    int            n_chk = 0;
    int            n_fail = 0;
    exp_t          sb_q[$];

    always #4 clk = ~clk;  // 125 MHz

    irq_reg_group #(.NUM_SRC(NS), .ADDR_W(AW)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr_en (bus_wr_en),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .hw_evt    (hw_evt),
        .irq_o     (irq_o)
    );

    function automatic logic m_irq();
        return |(m_sts & ~m_msk);
    endfunction

    // Register write with optional same-cycle events; updates the model
    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d,
                      input logic [NS-1:0] ev);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr_en = 1'b1; hw_evt = ev;
        @(negedge clk);
        bus_wr_en = 1'b0; hw_evt = '0; bus_wdata = '0;
        if (a == 8'h00) m_sts = m_sts & ~d[NS-1:0];
        if (a == 8'h08) m_msk = m_msk & ~d[NS-1:0];
        if (a == 8'h0C) m_msk = m_msk | d[NS-1:0];
        m_sts = m_sts | ev;
    endtask

    // Events alone
    task automatic evt(input logic [NS-1:0] ev);
        wr(8'h20, 32'h0, ev);
    endtask

    // Read; pushes the expected value and line level
    task automatic rd(input logic [AW-1:0] a, input logic [31:0] e, input string tag);
        exp_t it;
        @(negedge clk);
        bus_addr = a;
        it.rd = e; it.irq = m_irq(); it.tag = tag;
        sb_q.push_back(it);
        rd_pend = 1'b1;
        @(negedge clk);
        rd_pend = 1'b0;
    endtask

    task automatic chk_irq(input logic e, input string tag);
        n_chk++;
        if (irq_o !== e) begin
            n_fail++;
            $display("FAIL %s irq_o actual=%0b expected=%0b", tag, irq_o, e);
        end
    endtask

    // Monitor: pop and compare away from the edge
    always @(posedge clk) begin
        #2;
        if (rd_pend && sb_q.size() > 0) begin
            exp_t it;
            it = sb_q.pop_front();
            n_chk++;
            if (bus_rdata !== it.rd || irq_o !== it.irq) begin
                n_fail++;
                $display("FAIL %s rdata actual=%08h expected=%08h irq actual=%0b expected=%0b",
                         it.tag, bus_rdata, it.rd, irq_o, it.irq);
            end
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog (all requirements) actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk_irq(1'b0, "R1 during reset");
        rst_n = 1'b1;
        rd(8'h00, 32'h0, "R1 status reset");
        rd(8'h04, 32'hF, "R1 mask reset");
        rd(8'h08, 32'h0, "R9 unmask reads zero");
        rd(8'h0C, 32'h0, "R9 mask strobe reads zero");
        evt(4'b0001);
        rd(8'h00, 32'h1, "R3 event sets bit, R2 masked line low");
        wr(8'h04, 32'h0, '0);
        rd(8'h04, 32'hF, "R8 direct mask write ignored");
        wr(8'h08, 32'h1, '0);
        rd(8'h04, 32'hE, "R6 unmask bit0, R2 line high");
        rd(8'h08, 32'h0, "R9 unmask stores nothing");
        wr(8'h00, 32'h0, '0);
        rd(8'h00, 32'h1, "R4 write zero keeps bit");
        wr(8'h00, 32'h1, '0);
        rd(8'h00, 32'h0, "R4 write one clears, R2 line low");
        evt(4'b1010);
        rd(8'h00, 32'hA, "R3 two events, R11 upper bits zero");
        wr(8'h08, 32'h8, '0);
        rd(8'h04, 32'h6, "R6 unmask bit3 only");
        wr(8'h0C, 32'h8, '0);
        rd(8'h04, 32'hE, "R7 mask bit3 only");
        wr(8'h0C, 32'hFFFF_FFFF, '0);
        rd(8'h04, 32'hF, "R7 upper data ignored, R11");
        wr(8'h08, 32'h2, '0);
        wr(8'h00, 32'h2, 4'b0010);
        rd(8'h00, 32'hA, "R5 set wins over clear");
        wr(8'h01, 32'hF, '0);
        rd(8'h00, 32'hA, "R10 misaligned status write ignored");
        wr(8'h09, 32'hF, '0);
        rd(8'h04, 32'hD, "R10 misaligned unmask ignored");
        rd(8'h05, 32'h0, "R10 misaligned read zero");
        rd(8'h10, 32'h0, "R10 unmapped read zero");
        wr(8'h00, 32'hA, 4'b0001);
        rd(8'h00, 32'h1, "R4 clear other bits while R5 event sets bit0");
        // R2 one-clock lag: bit0 pending but masked (mask D), then unmask
        chk_irq(1'b0, "R2 before unmask");
        wr(8'h08, 32'h1, '0);
        chk_irq(1'b0, "R2 line not yet updated");
        @(negedge clk);
        chk_irq(1'b1, "R2 line one clock after mask change");
        wr(8'h00, 32'h1, '0);
        chk_irq(1'b1, "R2 line holds one clock after clear");
        @(negedge clk);
        chk_irq(1'b0, "R2 line drops after clear");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule